// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Decade Counter

This block is a four-bit counter advanced by two separate count strobes, one that raises the value and one that lowers it. A counting step happens on the low-to-high transition of a strobe. By default the counter steps through the decimal digits 0 to 9. A parameter changes it to a plain sixteen-state binary counter. The block also has a parallel preset with an active-low load, an active-high clear, and two active-low terminal-count outputs. These outputs can drive the strobe inputs of a following stage directly, so counters chain into multi-digit counters with no glue logic.

The counter runs in a single system-clock domain. Both strobes pass through a synchroniser chain and an edge detector. The clear acts on the state register at once, without waiting for the clock. The load is a level override that is sampled on every system clock. Each terminal-count output is the end-of-range condition gated by the low phase of its own synchronised strobe. The output therefore rises together with the strobe edge that moves the counter out of that state, and this rising transition is the carry or borrow edge for the next digit.

Top module: `updown_decade_counter`

## Requirements
- R1: In decimal mode (the default), a rising edge on `cnt_up` steps the count 0,1,...,9 and from 9 back to 0, and the value never leaves 0..9 once it is in that range.
- R2: A rising edge on `cnt_dn` lowers the count by one, and from 0 it wraps to 9 in decimal mode or to 15 in binary mode.
- R3: In binary mode the count steps up modulo 16 (9 goes to 10, 15 goes to 0).
- R4: The count changes only as a result of a detected strobe edge, the load or the clear. A strobe that stays high, stays low or falls leaves it unchanged.
- R5: `clear` high forces `count` to 0 immediately, without waiting for a clock edge, and takes priority over the load and both strobes.
- R6: While `load_n` is low (and `clear` is low), each system clock edge copies `preset` into `count`, whatever the strobes do. After `load_n` returns high, the value holds until the next strobe edge.
- R7: `carry_n` is low only when count bits 3 and 0 are both 1 (bits 3..0 all 1 in binary mode) and the synchronised `cnt_up` is low. It is high in every other case, including every cycle in which an up edge is being applied.
- R8: `borrow_n` is low only when the count is 0 and the synchronised `cnt_dn` is low. It is high in every other case.
- R9: If rising edges of `cnt_up` and `cnt_dn` are detected in the same system-clock cycle, the count does not change.
- R10: In decimal mode a loaded value from 10 to 15 counts up in binary (12 goes to 13, 15 goes to 0), after which the normal decimal sequence resumes. Counting down from 10 gives 9.
- R11: A strobe edge takes effect on the third system clock edge after the strobe input rises (two synchroniser stages followed by the state register). The synchroniser stages clear to 1, so strobes held high through a clear produce no count.
- R12: Two instances, each with the strobe inputs of the upper digit driven by the `carry_n` and `borrow_n` outputs of the lower digit, count 00 to 99 and back down to 00 without a missed or extra step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clear | input | 1 | Active-high clear, immediate, highest priority |
| load_n | input | 1 | Active-low parallel load |
| preset | input | 4 | Parallel load value |
| cnt_up | input | 1 | Count-up strobe, acts on its rising edge |
| cnt_dn | input | 1 | Count-down strobe, acts on its rising edge |
| count | output | 4 | Counter state |
| carry_n | output | 1 | Active-low terminal count up, usable as the next stage's up strobe |
| borrow_n | output | 1 | Active-low terminal count down, usable as the next stage's down strobe |

## Verification
The in-RTL assertions check on every cycle that the clear holds the count at zero and that a low load copies the preset. They also check that the count holds without a detected edge or when both edges coincide, that decimal mode stays in 0..9, and that the carry and borrow outputs are released while their own edge is being applied. Only the bench scenarios can show the actual step values and wrap points in both modes, the three-edge strobe latency, the asserted phases of carry and borrow, the stepping of loaded out-of-range decimal values, and the two-digit cascade running 00 to 99 and back.

// File: rtl/udc_pkg.sv
package udc_pkg;
   typedef enum logic {
      MODE_DECIMAL = 1'b0,
      MODE_BINARY  = 1'b1
   } count_mode_e;
endpackage

// File: rtl/udc_strobe_sync.sv
module udc_strobe_sync #(
   parameter int   STAGES    = 2,
   parameter logic IDLE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic clear,
   input  logic strobe,
   output logic level,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("udc_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
         chain_q <= {STAGES{IDLE_HIGH}};
         last_q  <= IDLE_HIGH;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], strobe};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~last_q;
endmodule

// File: rtl/udc_next_state.sv
module udc_next_state #(
   parameter int                  W    = 4,
   parameter udc_pkg::count_mode_e MODE = udc_pkg::MODE_DECIMAL
) (
   input  logic [W-1:0] cur,
   input  logic         step_up,
   input  logic         step_dn,
   output logic [W-1:0] nxt,
   output logic         at_top,
   output logic         at_bottom
);
   logic [W-1:0] top_val;
   logic         wrap_up;

   generate
      if (MODE == udc_pkg::MODE_DECIMAL) begin : g_dec
         assign top_val = W'(9);
         assign at_top  = cur[W-1] & cur[0];
         assign wrap_up = (cur == W'(9));
      end else begin : g_bin
         assign top_val = {W{1'b1}};
         assign at_top  = &cur;
         assign wrap_up = 1'b0;
      end
   endgenerate

   assign at_bottom = (cur == '0);

   always_comb begin
      nxt = cur;
      if (step_up && !step_dn) begin
         nxt = wrap_up ? '0 : cur + W'(1);
      end else if (step_dn && !step_up) begin
         nxt = at_bottom ? top_val : cur - W'(1);
      end
   end
endmodule

// File: rtl/updown_decade_counter.sv
module updown_decade_counter #(
   parameter int                   WIDTH       = 4,
   parameter udc_pkg::count_mode_e MODE        = udc_pkg::MODE_DECIMAL,
   parameter int                   SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             clear,
   input  logic             load_n,
   input  logic [WIDTH-1:0] preset,
   input  logic             cnt_up,
   input  logic             cnt_dn,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam int MAX_VAL = (MODE == udc_pkg::MODE_DECIMAL) ? 9 : (1 << WIDTH) - 1;

   generate
      if (MODE == udc_pkg::MODE_DECIMAL && WIDTH != 4) begin : g_bad_width
         $error("updown_decade_counter: decimal mode needs WIDTH of 4");
      end
   endgenerate

   logic             up_lvl, up_rise, dn_lvl, dn_rise;
   logic             at_top, at_bottom;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] count_q;

   udc_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_HIGH(1'b1)) up_sync_i (
      .clk(clk), .clear(clear), .strobe(cnt_up), .level(up_lvl), .rise(up_rise)
   );

   udc_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_HIGH(1'b1)) dn_sync_i (
      .clk(clk), .clear(clear), .strobe(cnt_dn), .level(dn_lvl), .rise(dn_rise)
   );

   udc_next_state #(.W(WIDTH), .MODE(MODE)) next_i (
      .cur(count_q), .step_up(up_rise), .step_dn(dn_rise),
      .nxt(nxt), .at_top(at_top), .at_bottom(at_bottom)
   );

   always_ff @(posedge clk or posedge clear) begin
      if (clear)        count_q <= '0;
      else if (!load_n) count_q <= preset;
      else              count_q <= nxt;
   end

   assign count    = count_q;
   assign carry_n  = ~(at_top & ~up_lvl);
   assign borrow_n = ~(at_bottom & ~dn_lvl);

   // R5: clear holds the state at zero
   assert_clr_zero_R5: assert property (@(posedge clk) clear |-> count == '0);

   // R6: load copies the preset on the next edge
   assert_load_R6: assert property (@(posedge clk) disable iff (clear)
      !load_n |=> count == $past(preset));

   // R4: without a detected edge the state holds
   assert_hold_R4: assert property (@(posedge clk) disable iff (clear)
      (load_n && !up_rise && !dn_rise) |=> $stable(count));

   // R9: coincident edges cancel
   assert_simul_R9: assert property (@(posedge clk) disable iff (clear)
      (load_n && up_rise && dn_rise) |=> $stable(count));

   // R7: carry released while an up edge is applied
   assert_carry_release_R7: assert property (@(posedge clk) disable iff (clear)
      up_rise |-> carry_n);

   // R8: borrow released while a down edge is applied
   assert_borrow_release_R8: assert property (@(posedge clk) disable iff (clear)
      dn_rise |-> borrow_n);

   generate
      if (MODE == udc_pkg::MODE_DECIMAL) begin : g_dec_chk
         // R1: decimal range is closed under counting
         assert_bcd_range_R1: assert property (@(posedge clk) disable iff (clear)
            (load_n && count <= WIDTH'(MAX_VAL)) |=> count <= WIDTH'(MAX_VAL));
      end
   endgenerate
endmodule

// File: tb/updown_decade_counter_tb.sv
module updown_decade_counter_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic       clear = 1'b1;
   logic       a_load_n = 1'b1, a_up = 1'b1, a_dn = 1'b1;
   logic [3:0] a_preset = '0;
   logic [3:0] a_q, h_q;
   logic       a_carry_n, a_borrow_n, h_carry_n, h_borrow_n;

   logic       b_load_n = 1'b1, b_up = 1'b1, b_dn = 1'b1;
   logic [3:0] b_preset = '0;
   logic [3:0] b_q;
   logic       b_carry_n, b_borrow_n;

   updown_decade_counter dut_i (
      .clk(clk), .clear(clear), .load_n(a_load_n), .preset(a_preset),
      .cnt_up(a_up), .cnt_dn(a_dn), .count(a_q),
      .carry_n(a_carry_n), .borrow_n(a_borrow_n));

   updown_decade_counter dut_hi (
      .clk(clk), .clear(clear), .load_n(1'b1), .preset(4'd0),
      .cnt_up(a_carry_n), .cnt_dn(a_borrow_n), .count(h_q),
      .carry_n(h_carry_n), .borrow_n(h_borrow_n));

   updown_decade_counter #(.MODE(udc_pkg::MODE_BINARY)) dut_bin (
      .clk(clk), .clear(clear), .load_n(b_load_n), .preset(b_preset),
      .cnt_up(b_up), .cnt_dn(b_dn), .count(b_q),
      .carry_n(b_carry_n), .borrow_n(b_borrow_n));

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_a(bit up);
      if (up) a_up = 1'b0; else a_dn = 1'b0;
      wait_n(4);
      if (up) a_up = 1'b1; else a_dn = 1'b1;
      wait_n(6);
   endtask

   task automatic pulse_b(bit up);
      if (up) b_up = 1'b0; else b_dn = 1'b0;
      wait_n(4);
      if (up) b_up = 1'b1; else b_dn = 1'b1;
      wait_n(6);
   endtask

   task automatic load_a(logic [3:0] v);
      a_preset = v; a_load_n = 1'b0; wait_n(1); a_load_n = 1'b1; wait_n(1);
   endtask

   task automatic load_b(logic [3:0] v);
      b_preset = v; b_load_n = 1'b0; wait_n(1); b_load_n = 1'b1; wait_n(1);
   endtask

   task automatic t_reset();
      chk("R5 reset count", a_q, 0);
      chk("R11 no count after clear with strobes high", a_q, 0);
      chk("R7 carry idle", a_carry_n, 1);
      chk("R8 borrow idle high strobe", a_borrow_n, 1);
   endtask

   task automatic t_decimal_up();
      for (int i = 1; i <= 10; i++) begin
         pulse_a(1'b1);
         chk("R1 decimal up", a_q, i % 10);
      end
      chk("R12 upper digit after carry", h_q, 1);
   endtask

   task automatic t_latency();
      load_a(4'd3);
      a_up = 1'b0; wait_n(4);
      a_up = 1'b1; wait_n(2);
      chk("R11 unchanged after two edges", a_q, 3);
      wait_n(1);
      chk("R11 changed on third edge", a_q, 4);
      wait_n(3);
      a_dn = 1'b0; wait_n(4);
      chk("R4 falling strobe no count", a_q, 4);
      wait_n(8);
      chk("R4 held low no count", a_q, 4);
      a_dn = 1'b1; wait_n(6);
      chk("R2 decrement", a_q, 3);
   endtask

   task automatic t_down_wrap();
      load_a(4'd0);
      a_dn = 1'b0; wait_n(4);
      chk("R8 borrow low at zero", a_borrow_n, 0);
      a_dn = 1'b1; wait_n(6);
      chk("R2 decimal wrap down", a_q, 9);
      chk("R8 borrow released", a_borrow_n, 1);
   endtask

   task automatic t_carry();
      load_a(4'd9);
      chk("R7 carry high with strobe high", a_carry_n, 1);
      a_up = 1'b0; wait_n(4);
      chk("R7 carry low at nine", a_carry_n, 0);
      chk("R8 borrow high at nine", a_borrow_n, 1);
      a_up = 1'b1; wait_n(2);
      chk("R7 carry released on edge", a_carry_n, 1);
      wait_n(4);
      chk("R1 wrap to zero", a_q, 0);
      load_a(4'd8);
      a_up = 1'b0; wait_n(4);
      chk("R7 no carry at eight", a_carry_n, 1);
      a_up = 1'b1; wait_n(6);
   endtask

   task automatic t_load();
      a_preset = 4'd6; a_load_n = 1'b0;
      a_up = 1'b0; wait_n(4); a_up = 1'b1; wait_n(6);
      chk("R6 load overrides strobe", a_q, 6);
      a_preset = 4'd2; wait_n(1);
      chk("R6 load follows preset", a_q, 2);
      a_load_n = 1'b1; a_preset = 4'd7; wait_n(5);
      chk("R6 holds after load released", a_q, 2);
   endtask

   task automatic t_clear();
      load_a(4'd5);
      @(negedge clk);
      a_load_n = 1'b0; a_preset = 4'd8;
      #3 clear = 1'b1;
      #1 chk("R5 immediate clear", a_q, 0);
      wait_n(2);
      chk("R5 clear over load", a_q, 0);
      clear = 1'b0; a_load_n = 1'b1; wait_n(2);
      chk("R5 after clear", a_q, 0);
   endtask

   task automatic t_simul();
      load_a(4'd4);
      a_up = 1'b0; a_dn = 1'b0; wait_n(4);
      a_up = 1'b1; a_dn = 1'b1; wait_n(6);
      chk("R9 coincident edges", a_q, 4);
   endtask

   task automatic t_out_of_range();
      load_a(4'd12);
      pulse_a(1'b1);
      chk("R10 twelve to thirteen", a_q, 13);
      load_a(4'd15);
      pulse_a(1'b1);
      chk("R10 fifteen to zero", a_q, 0);
      load_a(4'd10);
      pulse_a(1'b0);
      chk("R10 ten down to nine", a_q, 9);
   endtask

   task automatic t_binary();
      load_b(4'd9);
      pulse_b(1'b1);
      chk("R3 nine to ten binary", b_q, 10);
      load_b(4'd15);
      b_up = 1'b0; wait_n(4);
      chk("R7 binary carry at fifteen", b_carry_n, 0);
      b_up = 1'b1; wait_n(6);
      chk("R3 binary wrap up", b_q, 0);
      pulse_b(1'b0);
      chk("R2 binary wrap down", b_q, 15);
   endtask

   task automatic t_cascade();
      clear = 1'b1; wait_n(2); clear = 1'b0; wait_n(2);
      for (int i = 1; i <= 99; i++) begin
         pulse_a(1'b1);
         tests++;
         if (h_q * 10 + a_q != i) begin
            fails++;
            $display("FAIL R12 cascade up: actual %0d expected %0d", h_q * 10 + a_q, i);
         end
      end
      for (int i = 98; i >= 0; i--) begin
         pulse_a(1'b0);
         tests++;
         if (h_q * 10 + a_q != i) begin
            fails++;
            $display("FAIL R12 cascade down: actual %0d expected %0d", h_q * 10 + a_q, i);
         end
      end
      a_dn = 1'b0; wait_n(4);
      chk("R12 lower borrow at 00", a_borrow_n, 0);
      chk("R12 upper borrow at 00", h_borrow_n, 0);
      a_dn = 1'b1; wait_n(6);
   endtask

   initial begin
      wait_n(3);
      clear = 1'b0;
      wait_n(3);
      t_reset();
      t_decimal_up();
      t_latency();
      t_down_wrap();
      t_carry();
      t_load();
      t_clear();
      t_simul();
      t_out_of_range();
      t_binary();
      t_cascade();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule